// File: doc/BRIEF.md
# Differential Escalation Responder

This block sits at the receiving end of a complementary-pair escalation link. One input pair, `esc_p`/`esc_n`, carries two kinds of traffic:

- **Liveness ping:** a single-cycle high pulse on `esc_p`.
- **Real escalation request:** `esc_p` held high for two or more cycles.

The block tells the two apart by pulse length. It answers each on a complementary output pair, `resp_p`/`resp_n`, with its own toggle pattern. While a real request lasts, it also holds a local `esc_active` flag high.

The input pair is checked on every cycle. If both wires carry the same level, the input encoding is broken. The block reports this back to the sender by driving both response wires to the same level on the next cycle. A broken cycle is never read as a request. Because of this, a one-cycle ping that arrives with a broken encoding cannot be recognised as a ping and produces no ping answer.

All outputs are registered. Each output reflects the input pair one clock edge earlier. Reset is synchronous and active-high.

Top module: `esc_responder`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `resp_p`=0, `resp_n`=1, `esc_active`=0, whatever the input pair carries. After release, the block starts from idle.
- R2: If `esc_p` equals `esc_n` in cycle k, then in cycle k+1 both `resp_p` and `resp_n` equal the parameter `FAULT_LEVEL` (default 0) and `esc_active` is 0. Any running ping or escalation sequence is abandoned, and the block restarts from idle.
- R3: In every cycle whose preceding input cycle had `esc_p`≠`esc_n`, `resp_n` is the complement of `resp_p`. When idle, `resp_p` is 0.
- R4: A valid high cycle on `esc_p` in cycle t, starting from idle and followed by a valid low cycle, produces `resp_p` = 0, 1, 0, 1 in cycles t+1 to t+4 and 0 in t+5. `esc_active` stays 0 throughout.
- R5: If `esc_p` is validly high in cycles t to t+L-1 (L≥2) from idle, then `resp_p` in cycle t+1+i equals i mod 2 for 0≤i<L. In cycle t+L+1, `resp_p` is back at idle 0.
- R6: For such a request, `esc_active` is 1 in cycles t+2 to t+L and 0 in cycle t+L+1, the cycle after the first low cycle of `esc_p`.
- R7: A valid high cycle arriving while a ping answer is in its high, low or second-high step cancels that pattern. The block treats that cycle as the start of a new request, as in R4 or R5: the ping pattern restarts if the pulse lasts one cycle, and the escalation pattern begins if it lasts longer.
- R8: A single-cycle `esc_p`=`esc_n`=1 pulse from idle gives one fault cycle (R2). It is followed by plain idle (`resp_p`=0, `resp_n`=1), with no ping pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| esc_p | input | 1 | Escalation/ping line, true polarity |
| esc_n | input | 1 | Escalation/ping line, inverted polarity |
| resp_p | output | 1 | Response line, true polarity |
| resp_n | output | 1 | Response line, inverted polarity; equals resp_p during a fault |
| esc_active | output | 1 | High while a real escalation request is being honoured |

## Verification
The bench builds the block with its default `FAULT_LEVEL` of 0, so fault cycles show up as both response wires low. The vector table covers the following patterns:

- a lone ping;
- escalations of two and four cycles;
- an escalation that cuts into the low step of a ping;
- a single pulse that restarts a ping from its second-high step;
- both kinds of broken encoding (1/1 and 0/0);
- a broken cycle in the middle of an escalation, followed by a fresh request.

Directed tests apply reset with a request pending on the input and in the middle of an escalation. They confirm that the block comes back idle and does not resume the old sequence.

// File: rtl/esc_responder_pkg.sv
package esc_responder_pkg;

  localparam int unsigned NUM_STATES = 7;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 3'd0,
    ST_CHECK    = 3'd1,
    ST_PING_HI1 = 3'd2,
    ST_PING_LO  = 3'd3,
    ST_PING_HI2 = 3'd4,
    ST_ESC_HI   = 3'd5,
    ST_ESC_LO   = 3'd6
  } resp_state_e;

  // Response level carried on the true wire for each state
  function automatic logic state_level(resp_state_e s);
    return (s == ST_PING_HI1) || (s == ST_PING_HI2) || (s == ST_ESC_HI);
  endfunction

endpackage

// File: rtl/esc_responder_decode.sv
// Classifies one cycle of the input pair.
module esc_responder_decode (
  input  logic esc_p,
  input  logic esc_n,
  output logic in_hi,
  output logic in_err
);

  // Equal levels on a complementary pair mean broken encoding
  assign in_err = ~(esc_p ^ esc_n);
  // A valid high cycle on the true wire
  assign in_hi  = esc_p & ~esc_n;

endmodule

// File: rtl/esc_responder_seq.sv
// Response sequencer: separates pings from sustained requests.
module esc_responder_seq
  import esc_responder_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_hi,
  input  logic in_err,
  output logic nxt_level,
  output logic nxt_active
);

  resp_state_e state_q, state_d;

  always_comb begin
    state_d = ST_IDLE;
    if (!in_err) begin
      unique case (state_q)
        ST_IDLE:     state_d = in_hi ? ST_CHECK  : ST_IDLE;
        ST_CHECK:    state_d = in_hi ? ST_ESC_HI : ST_PING_HI1;
        // a high cycle during a ping answer starts a new request
        ST_PING_HI1: state_d = in_hi ? ST_CHECK  : ST_PING_LO;
        ST_PING_LO:  state_d = in_hi ? ST_CHECK  : ST_PING_HI2;
        ST_PING_HI2: state_d = in_hi ? ST_CHECK  : ST_IDLE;
        ST_ESC_HI:   state_d = in_hi ? ST_ESC_LO : ST_IDLE;
        ST_ESC_LO:   state_d = in_hi ? ST_ESC_HI : ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign nxt_level  = state_level(state_d);
  assign nxt_active = in_hi & ((state_q == ST_CHECK) ||
                               (state_q == ST_ESC_HI) ||
                               (state_q == ST_ESC_LO));

  // Escalation states are entered only from a valid high input cycle
  AST_ESC_NEEDS_HI: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ESC_HI) || (state_q == ST_ESC_LO)) |-> $past(in_hi)); // R5

endmodule

// File: rtl/esc_responder_oreg.sv
// Output register stage; breaks the response encoding on a fault.
module esc_responder_oreg #(
  parameter logic FAULT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_err,
  input  logic nxt_level,
  input  logic nxt_active,
  output logic resp_p,
  output logic resp_n,
  output logic esc_active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_p     <= 1'b0;
      resp_n     <= 1'b1;
      esc_active <= 1'b0;
    end else if (in_err) begin
      resp_p     <= FAULT_LEVEL;
      resp_n     <= FAULT_LEVEL;
      esc_active <= 1'b0;
    end else begin
      resp_p     <= nxt_level;
      resp_n     <= ~nxt_level;
      esc_active <= nxt_active;
    end
  end

  AST_RESP_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    !in_err |=> (resp_p != resp_n)); // R3

  AST_FAULT_SIGNALLED: assert property (@(posedge clk) disable iff (rst)
    in_err |=> ((resp_p == resp_n) && !esc_active)); // R2

endmodule

// File: rtl/esc_responder.sv
module esc_responder #(
  parameter logic FAULT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic esc_p,
  input  logic esc_n,
  output logic resp_p,
  output logic resp_n,
  output logic esc_active
);

  logic in_hi, in_err, nxt_level, nxt_active;

  esc_responder_decode u_decode (
    .esc_p  (esc_p),
    .esc_n  (esc_n),
    .in_hi  (in_hi),
    .in_err (in_err)
  );

  esc_responder_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_hi      (in_hi),
    .in_err     (in_err),
    .nxt_level  (nxt_level),
    .nxt_active (nxt_active)
  );

  esc_responder_oreg #(
    .FAULT_LEVEL (FAULT_LEVEL)
  ) u_oreg (
    .clk        (clk),
    .rst        (rst),
    .in_err     (in_err),
    .nxt_level  (nxt_level),
    .nxt_active (nxt_active),
    .resp_p     (resp_p),
    .resp_n     (resp_n),
    .esc_active (esc_active)
  );

  // Active flag clears one cycle after the request ends
  AST_ACTIVE_DROP: assert property (@(posedge clk) disable iff (rst)
    !(esc_p && !esc_n) |=> !esc_active); // R6

  // While a request is honoured the response toggles each cycle
  AST_ESC_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (esc_active && esc_p && !esc_n) |=> (resp_p != $past(resp_p))); // R5

endmodule

// File: tb/esc_responder_tb.sv
module esc_responder_tb;

  logic clk = 1'b0;
  logic rst;
  logic esc_p, esc_n;
  logic resp_p, resp_n, esc_active;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  esc_responder u_dut (
    .clk        (clk),
    .rst        (rst),
    .esc_p      (esc_p),
    .esc_n      (esc_n),
    .resp_p     (resp_p),
    .resp_n     (resp_n),
    .esc_active (esc_active)
  );

  // Row: {requirement[3:0], esc_p, esc_n, exp resp_p, exp resp_n, exp esc_active}
  // Expected values are the outputs after the edge that captures the row's inputs.
  localparam int NVEC = 42;
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0100_10010, 9'b0100_01100, 9'b0100_01010, 9'b0100_01100, 9'b0100_01010, // R4 ping
    9'b0011_01010,                                                              // R3 idle
    9'b0101_10010, 9'b0110_10101, 9'b0101_10011, 9'b0110_10101, 9'b0110_01010, // R5 R6 L=4
    9'b0011_01010,
    9'b0111_10010, 9'b0111_01100, 9'b0111_01010, 9'b0111_10010, 9'b0111_10101, // R7 escalation
    9'b0111_10011, 9'b0111_01010,                                               //    cuts ping
    9'b0111_10010, 9'b0111_01100, 9'b0111_01010, 9'b0111_01100, 9'b0111_10010, // R7 ping restart
    9'b0111_01100, 9'b0111_01010, 9'b0111_01100, 9'b0111_01010,
    9'b1000_11000, 9'b1000_01010, 9'b1000_01010,                                // R8 broken ping
    9'b0010_00000, 9'b0011_01010,                                               // R2 0/0 pair
    9'b0101_10010, 9'b0110_10101, 9'b0010_11000, 9'b0010_10010, 9'b0010_10101, // R2 mid-escalation
    9'b0110_01010,
    9'b0101_10010, 9'b0101_10101, 9'b0110_01010                                 // R5 L=2
  };

  task automatic check3(input string req, input logic xp, input logic xn, input logic xa);
    checks++;
    if (resp_p !== xp || resp_n !== xn || esc_active !== xa) begin
      failures++;
      $display("FAIL %s: actual p=%b n=%b act=%b expected p=%b n=%b act=%b",
               req, resp_p, resp_n, esc_active, xp, xn, xa);
    end
  endtask

  task automatic step(input logic p, input logic n);
    esc_p = p;
    esc_n = n;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; esc_p = 1'b1; esc_n = 1'b0; // request pending during reset
    repeat (3) @(negedge clk);
    check3("R1", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    esc_p = 1'b0; esc_n = 1'b1;
    @(negedge clk);
    check3("R1", 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check3($sformatf("R%0d row %0d", VEC[i][8:5], i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of an escalation
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check3("R6", 1'b1, 1'b0, 1'b1);
    rst = 1'b1;
    step(1'b1, 1'b0);
    check3("R1", 1'b0, 1'b1, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b1);
    check3("R1", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1);
    check3("R3", 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule